// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the register state for one bank of general-purpose I/O: four ports of eight pins each. A 32-bit register bus reaches it. The bus has a byte address, a write strobe, write data and read data that returns in the same cycle. For every pin the block stores:

- whether the pin is owned by GPIO
- the output direction
- the driven value
- the interrupt enable
- the interrupt trigger type
- the debounce enable

It also stores one debounce count per port. From these it drives the pad output-enable and output-value lines. It forwards the interrupt and debounce settings to the detection and debounce blocks, which sit outside it.

Every writable per-pin register also has a masked alias. In the alias, the upper byte of the write data picks which pins the lower byte updates, so software can change one pin with a single write and no read-modify-write. Pad inputs are resynchronised before software can read them. Interrupt status arrives from the detection logic as an input and is only read here. A write to the clear group produces a one-cycle clear pulse for each selected pin.

Top module: `gpio_rf`

## Requirements
- R1: After reset every register is 0: pad_oe, pad_out, int_en, int_type, dbc_en, dbc_cnt and irq_clr are all 0, and a read of any group returns 0 while pad_in and irq_sts are 0.
- R2: Register address fields. Within the bank, addr[7:4] selects the register group and addr[3:2] selects the port; addr[1:0] is ignored. The direct groups are 0x0 configuration, 0x1 direction, 0x2 output value, 0x3 input, 0x5 interrupt enable, 0x6 interrupt type and 0xF debounce count.
- R3: Direct writes and read-back. A direct write loads wdata[7:0]; the interrupt type group loads wdata[23:0], laid out as bits 7:0 level/polarity, 15:8 edge select and 23:16 both-edge. The debounce count group loads an 8-bit value. Reads return the stored value zero-extended, in the same cycle as the address.
- R4: Masked aliases live at groups 0x8 configuration, 0x9 direction, 0xA output value, 0xB debounce enable, 0xD interrupt enable and 0xE interrupt type. On a write to an alias, wdata[8+k] set means pin k takes wdata[k]. The type alias updates only bits 7:0 of the type register. Reading an alias returns the underlying register.
- R5: pad_oe for pin k of port p, at bit 8p+k, is the configuration bit AND the direction bit. pad_out carries the output value register.
- R6: A read of the input group returns the pad_in byte for that port as it was sampled two rising edges earlier, through a two-stage synchronizer.
- R7: A write to group 0x7 raises irq_clr[8p+k] for each set wdata[k], for exactly the one cycle after the write. A read of group 0x7 returns 0.
- R8: A read of group 0x4 or 0xC returns the irq_sts byte for the port. A write to either group changes nothing.
- R9: Writes to the input group, and any access at or above byte address 0x100, leave all state unchanged. Reads at or above 0x100 return 0.
- R10: A masked write whose mask byte is 0 leaves the register unchanged.
- R11: int_en, int_type, dbc_en and dbc_cnt present the stored registers, port p at slice p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 12 | Byte address within the bank window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pad_in | input | 32 | Raw pad levels, pin 8p+k |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_sts | input | 32 | Interrupt status from the detection block |
| irq_clr | output | 32 | One-cycle interrupt clear pulses |
| int_en | output | 32 | Interrupt enables per pin |
| int_type | output | 96 | Interrupt type, 24 bits per port |
| dbc_en | output | 32 | Debounce enables per pin |
| dbc_cnt | output | 32 | Debounce count, 8 bits per port |

## Verification
Two things can happen in the same cycle: a register write and the synchronizer shifting in a new pad level. The bench provokes this in two ways.

- A masked write to the output alias lands on the very edge where pad_in changes. The bench then reads both the output register and the input group. It expects the merged output value, and it expects the new pad byte two edges later.
- A write to the input group is issued in the same cycle as a pad change. The bench judges it by the input group reading back the pad byte rather than the write data.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

    // Register group, equal to address bits 7:4 inside the bank window.
    typedef enum logic [3:0] {
        G_CFG   = 4'h0,
        G_OE    = 4'h1,
        G_OUT   = 4'h2,
        G_IN    = 4'h3,
        G_STS   = 4'h4,
        G_IEN   = 4'h5,
        G_ITYP  = 4'h6,
        G_CLR   = 4'h7,
        G_MCFG  = 4'h8,
        G_MOE   = 4'h9,
        G_MOUT  = 4'hA,
        G_MDBE  = 4'hB,
        G_MSTS  = 4'hC,
        G_MIEN  = 4'hD,
        G_MITYP = 4'hE,
        G_DBC   = 4'hF
    } grp_e;

    localparam int DATA_W   = 32;
    localparam int MASK_LSB = 8;   // mask byte position in a masked write
    localparam int DBC_W    = 8;   // debounce count width

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output grp_e              grp,
    output logic [1:0]        port
);
    localparam int WIN_BITS = 8;   // 256-byte bank window

    always_comb begin
        grp  = grp_e'(addr[7:4]);
        port = addr[3:2];
        hit  = (addr[ADDR_W-1:WIN_BITS] == '0) &&
               ({1'b0, addr[3:2]} < 3'(NUM_PORTS));
    end
endmodule

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gpio_rf_port.sv
module gpio_rf_port
    import gpio_rf_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 we,
    input  grp_e                 grp,
    input  logic [DATA_W-1:0]    wdata,
    output logic [PINS-1:0]      cfg,
    output logic [PINS-1:0]      oe,
    output logic [PINS-1:0]      out,
    output logic [PINS-1:0]      dbe,
    output logic [PINS-1:0]      ien,
    output logic [3*PINS-1:0]    ityp,
    output logic [DBC_W-1:0]     dbc,
    output logic [PINS-1:0]      clr
);
    localparam int TYP_W = 3 * PINS;

    typedef struct packed {
        logic [PINS-1:0]  cfg;
        logic [PINS-1:0]  oe;
        logic [PINS-1:0]  out;
        logic [PINS-1:0]  dbe;
        logic [PINS-1:0]  ien;
        logic [TYP_W-1:0] ityp;
        logic [DBC_W-1:0] dbc;
        logic [PINS-1:0]  clr;
    } port_t;

    port_t st_d, st_q;

    logic [PINS-1:0] wmask, wval;
    assign wmask = wdata[MASK_LSB +: PINS];
    assign wval  = wdata[PINS-1:0];

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old);
        return (old & ~wmask) | (wval & wmask);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.clr = '0;
        if (sel && we) begin
            unique case (grp)
                G_CFG:   st_d.cfg  = wval;
                G_OE:    st_d.oe   = wval;
                G_OUT:   st_d.out  = wval;
                G_IEN:   st_d.ien  = wval;
                G_ITYP:  st_d.ityp = wdata[TYP_W-1:0];
                G_DBC:   st_d.dbc  = wdata[DBC_W-1:0];
                G_CLR:   st_d.clr  = wval;
                G_MCFG:  st_d.cfg  = merge(st_q.cfg);
                G_MOE:   st_d.oe   = merge(st_q.oe);
                G_MOUT:  st_d.out  = merge(st_q.out);
                G_MDBE:  st_d.dbe  = merge(st_q.dbe);
                G_MIEN:  st_d.ien  = merge(st_q.ien);
                G_MITYP: st_d.ityp[PINS-1:0] = merge(st_q.ityp[PINS-1:0]);
                default: ;   // input and status groups are read-only
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign oe   = st_q.oe;
    assign out  = st_q.out;
    assign dbe  = st_q.dbe;
    assign ien  = st_q.ien;
    assign ityp = st_q.ityp;
    assign dbc  = st_q.dbc;
    assign clr  = st_q.clr;
endmodule

// File: rtl/gpio_rf.sv
module gpio_rf
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    input  logic [NUM_PORTS*PINS-1:0]       pad_in,
    output logic [NUM_PORTS*PINS-1:0]       pad_out,
    output logic [NUM_PORTS*PINS-1:0]       pad_oe,
    input  logic [NUM_PORTS*PINS-1:0]       irq_sts,
    output logic [NUM_PORTS*PINS-1:0]       irq_clr,
    output logic [NUM_PORTS*PINS-1:0]       int_en,
    output logic [NUM_PORTS*3*PINS-1:0]     int_type,
    output logic [NUM_PORTS*PINS-1:0]       dbc_en,
    output logic [NUM_PORTS*DBC_W-1:0]      dbc_cnt
);
    localparam int NPIN  = NUM_PORTS * PINS;
    localparam int TYP_W = 3 * PINS;

    logic       hit;
    grp_e       grp;
    logic [1:0] port;

    gpio_rf_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
        .addr (addr),
        .hit  (hit),
        .grp  (grp),
        .port (port)
    );

    logic [NPIN-1:0] in_sync;

    gpio_rf_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (in_sync)
    );

    logic [PINS-1:0]  cfg_a  [NUM_PORTS];
    logic [PINS-1:0]  oe_a   [NUM_PORTS];
    logic [PINS-1:0]  out_a  [NUM_PORTS];
    logic [PINS-1:0]  dbe_a  [NUM_PORTS];
    logic [PINS-1:0]  ien_a  [NUM_PORTS];
    logic [TYP_W-1:0] ityp_a [NUM_PORTS];
    logic [DBC_W-1:0] dbc_a  [NUM_PORTS];
    logic [PINS-1:0]  clr_a  [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel_p;
        assign sel_p = hit && (port == 2'(p));

        gpio_rf_port #(.PINS(PINS)) u_port (
            .clk   (clk),
            .rst   (rst),
            .sel   (sel_p),
            .we    (we),
            .grp   (grp),
            .wdata (wdata),
            .cfg   (cfg_a[p]),
            .oe    (oe_a[p]),
            .out   (out_a[p]),
            .dbe   (dbe_a[p]),
            .ien   (ien_a[p]),
            .ityp  (ityp_a[p]),
            .dbc   (dbc_a[p]),
            .clr   (clr_a[p])
        );

        assign pad_oe [p*PINS  +: PINS]  = cfg_a[p] & oe_a[p];
        assign pad_out[p*PINS  +: PINS]  = out_a[p];
        assign irq_clr[p*PINS  +: PINS]  = clr_a[p];
        assign int_en [p*PINS  +: PINS]  = ien_a[p];
        assign dbc_en [p*PINS  +: PINS]  = dbe_a[p];
        assign int_type[p*TYP_W +: TYP_W] = ityp_a[p];
        assign dbc_cnt[p*DBC_W +: DBC_W] = dbc_a[p];
    end

    // Read mux: same-cycle data for the addressed register.
    logic [31:0] rd_d;

    always_comb begin
        rd_d = '0;
        if (hit) begin
            unique case (grp)
                G_CFG,  G_MCFG:  rd_d = 32'(cfg_a[port]);
                G_OE,   G_MOE:   rd_d = 32'(oe_a[port]);
                G_OUT,  G_MOUT:  rd_d = 32'(out_a[port]);
                G_IN:            rd_d = 32'(in_sync[port*PINS +: PINS]);
                G_STS,  G_MSTS:  rd_d = 32'(irq_sts[port*PINS +: PINS]);
                G_IEN,  G_MIEN:  rd_d = 32'(ien_a[port]);
                G_ITYP, G_MITYP: rd_d = 32'(ityp_a[port]);
                G_MDBE:          rd_d = 32'(dbe_a[port]);
                G_DBC:           rd_d = 32'(dbc_a[port]);
                default:         rd_d = '0;   // clear group reads zero
            endcase
        end
    end

    assign rdata = rd_d;
endmodule

// File: rtl/gpio_rf_chk.sv
module gpio_rf_chk #(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      we,
    input logic [ADDR_W-1:0]         addr,
    input logic [31:0]               wdata,
    input logic [31:0]               rdata,
    input logic [NUM_PORTS*PINS-1:0] pad_in,
    input logic [NUM_PORTS*PINS-1:0] pad_out,
    input logic [NUM_PORTS*PINS-1:0] pad_oe,
    input logic [NUM_PORTS*PINS-1:0] irq_clr,
    input logic [NUM_PORTS*PINS-1:0] int_en
);
    localparam int NPIN = NUM_PORTS * PINS;

    logic            in_rng;
    logic [3:0]      g;
    logic [NPIN-1:0] clr_exp;
    logic [1:0]      age_q;

    assign in_rng  = (addr[ADDR_W-1:8] == '0) && ({1'b0, addr[3:2]} < 3'(NUM_PORTS));
    assign g       = addr[7:4];
    assign clr_exp = NPIN'(wdata[PINS-1:0]) << (PINS * addr[3:2]);

    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (we && in_rng && g == 4'h7) |=> (irq_clr == $past(clr_exp)));

    // R7
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(we && in_rng && g == 4'h7) |=> (irq_clr == '0));

    // R10
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (we && in_rng && g == 4'hA && wdata[8 +: PINS] == '0) |=> $stable(pad_out));

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (!in_rng || g == 4'h3 || g == 4'h4 || g == 4'hC))
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(int_en)));

    // R5
    out_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (in_rng && g == 4'h2) |-> (rdata == 32'(PINS'(pad_out >> (PINS * addr[3:2])))));

    // R6
    sync_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && in_rng && g == 4'h3)
        |-> (rdata == 32'(PINS'($past(pad_in, 2) >> (PINS * addr[3:2])))));
endmodule

bind gpio_rf gpio_rf_chk #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PINS(PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .irq_clr (irq_clr),
    .int_en  (int_en)
);

// File: tb/tb_gpio_rf.sv
`timescale 1ns/1ps
module tb_gpio_rf;
    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] pad_in, pad_out, pad_oe, irq_sts, irq_clr, int_en, dbc_en, dbc_cnt;
    logic [95:0] int_type;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_rf dut (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_sts(irq_sts),
        .irq_clr(irq_clr), .int_en(int_en), .int_type(int_type), .dbc_en(dbc_en),
        .dbc_cnt(dbc_cnt)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h0000_00A5, 1'b0, 32'h0,         4'd2},  // R2 cfg p0
        '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_00A5, 4'd3},
        '{1'b1, 12'h010, 32'h0000_000F, 1'b0, 32'h0,         4'd2},
        '{1'b0, 12'h010, 32'h0,         1'b1, 32'h0000_000F, 4'd3},
        '{1'b1, 12'h020, 32'h0000_003C, 1'b0, 32'h0,         4'd2},
        '{1'b0, 12'h020, 32'h0,         1'b1, 32'h0000_003C, 4'd3},
        '{1'b1, 12'h0A0, 32'h0000_8101, 1'b0, 32'h0,         4'd4},  // R4 masked out
        '{1'b0, 12'h020, 32'h0,         1'b1, 32'h0000_003D, 4'd4},
        '{1'b0, 12'h0A0, 32'h0,         1'b1, 32'h0000_003D, 4'd4},
        '{1'b1, 12'h0A0, 32'h0000_00FF, 1'b0, 32'h0,         4'd10}, // R10 zero mask
        '{1'b0, 12'h020, 32'h0,         1'b1, 32'h0000_003D, 4'd10},
        '{1'b1, 12'h008, 32'h0000_0077, 1'b0, 32'h0,         4'd2},  // R2 port 2
        '{1'b0, 12'h00B, 32'h0,         1'b1, 32'h0000_0077, 4'd2},
        '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_00A5, 4'd2},
        '{1'b1, 12'h064, 32'h00AB_CDEF, 1'b0, 32'h0,         4'd3},  // R3 type p1
        '{1'b0, 12'h064, 32'h0,         1'b1, 32'h00AB_CDEF, 4'd3},
        '{1'b1, 12'h0E4, 32'h0000_0F30, 1'b0, 32'h0,         4'd4},
        '{1'b0, 12'h064, 32'h0,         1'b1, 32'h00AB_CDE0, 4'd4},
        '{1'b1, 12'h0FC, 32'h1234_5678, 1'b0, 32'h0,         4'd3},  // R3 debounce count
        '{1'b0, 12'h0FC, 32'h0,         1'b1, 32'h0000_0078, 4'd3},
        '{1'b1, 12'h0B4, 32'h0000_FF5A, 1'b0, 32'h0,         4'd4},
        '{1'b0, 12'h0B4, 32'h0,         1'b1, 32'h0000_005A, 4'd4},
        '{1'b1, 12'h058, 32'h0000_0099, 1'b0, 32'h0,         4'd3},
        '{1'b0, 12'h058, 32'h0,         1'b1, 32'h0000_0099, 4'd3},
        '{1'b1, 12'h0D8, 32'h0000_0300, 1'b0, 32'h0,         4'd4},
        '{1'b0, 12'h058, 32'h0,         1'b1, 32'h0000_0098, 4'd4},
        '{1'b1, 12'h030, 32'h0000_00FF, 1'b0, 32'h0,         4'd9},  // R9 input write
        '{1'b0, 12'h030, 32'h0,         1'b1, 32'h0000_0000, 4'd9},
        '{1'b1, 12'h100, 32'h0000_00FF, 1'b0, 32'h0,         4'd9},  // R9 outside window
        '{1'b0, 12'h100, 32'h0,         1'b1, 32'h0000_0000, 4'd9},
        '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_00A5, 4'd9},
        '{1'b0, 12'h070, 32'h0,         1'b1, 32'h0000_0000, 4'd7},  // R7 clear reads 0
        '{1'b1, 12'h0C0, 32'h0000_00FF, 1'b0, 32'h0,         4'd8},  // R8 status write
        '{1'b0, 12'h0C0, 32'h0,         1'b1, 32'h0000_0000, 4'd8}
    };

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = w; addr = a; wdata = d;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; pad_in = '0; irq_sts = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 pad_oe",  96'(pad_oe), 96'h0);
        check("R1 pad_out", 96'(pad_out), 96'h0);
        check("R1 cfg",     {int_type, 32'(int_en | dbc_en | dbc_cnt | irq_clr)}, 96'h0);
        bus(1'b0, 12'h020, 32'h0);
        check("R1 read", 96'(rdata), 96'h0);

        for (int i = 0; i < NV; i++) begin
            bus(VECS[i].wr, VECS[i].a, VECS[i].d);
            if (VECS[i].chk) begin
                checks++;
                if (rdata !== VECS[i].exp) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual %0h expected %0h",
                             VECS[i].req, i, rdata, VECS[i].exp);
                end
            end
        end
        bus(1'b0, 12'h000, 32'h0);

        // R5 pad controls: port0 cfg A5 & oe 0F, port2 cfg 77 with oe 0
        check("R5 pad_oe",  96'(pad_oe), 96'h0000_0005);
        check("R5 pad_out", 96'(pad_out[7:0]), 96'h3D);
        // R11 forwarded settings
        check("R11 int_type", 96'(int_type[47:24]), 96'hABCDE0);
        check("R11 dbc_cnt",  96'(dbc_cnt[31:24]), 96'h78);
        check("R11 dbc_en",   96'(dbc_en), 96'h0000_5A00);
        check("R11 int_en",   96'(int_en), 96'h0098_0000);

        // R6 two-stage synchronizer depth
        bus(1'b0, 12'h034, 32'h0);
        pad_in = 32'h1122_3344;
        #1 check("R6 edge0", 96'(rdata), 96'h0);
        bus(1'b0, 12'h034, 32'h0);
        check("R6 edge1", 96'(rdata), 96'h0);
        bus(1'b0, 12'h034, 32'h0);
        check("R6 edge2", 96'(rdata), 96'h33);

        // R8 status groups follow irq_sts
        irq_sts = 32'hA500_0000;
        bus(1'b0, 12'h0CC, 32'h0);
        check("R8 masked sts", 96'(rdata), 96'hA5);
        bus(1'b1, 12'h04C, 32'h0);
        check("R8 direct sts", 96'(rdata), 96'hA5);
        irq_sts = '0;

        // R7 clear pulse for port 2, one cycle after the write
        bus(1'b1, 12'h078, 32'h0000_00C3);
        check("R7 before edge", 96'(irq_clr), 96'h0);
        bus(1'b0, 12'h000, 32'h0);
        check("R7 pulse", 96'(irq_clr), 96'h00C3_0000);
        bus(1'b0, 12'h000, 32'h0);
        check("R7 one cycle", 96'(irq_clr), 96'h0);

        // R4 and R6 together: masked output write on the edge that samples a pad change
        @(negedge clk);
        we = 1'b1; addr = 12'h0A0; wdata = 32'h0000_0202; pad_in = 32'h0000_00F0;
        bus(1'b0, 12'h020, 32'h0);
        check("R4 concurrent out", 96'(rdata), 96'h3F);
        bus(1'b0, 12'h030, 32'h0);
        check("R6 concurrent in", 96'(rdata), 96'hF0);

        // R9 and R6: input-group write in the same cycle as a pad change
        @(negedge clk);
        we = 1'b1; addr = 12'h030; wdata = 32'h0000_00AA; pad_in = 32'h0000_000F;
        bus(1'b0, 12'h030, 32'h0);
        bus(1'b0, 12'h030, 32'h0);
        check("R9 input write ignored", 96'(rdata), 96'h0F);
        check("R9 pads unchanged", 96'({pad_oe, pad_out}), 96'({32'h5, 32'h3F}));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule